// File: doc/BRIEF.md
# Switch Sequence Memory Game

This block runs a memory game played on four switches. A fixed ten-step sequence of one-hot patterns is built into the block. In round N the player must enter the first N patterns in order. Each time the player finishes the required prefix correctly, the block pulses a success flag, moves to the next round and expects the sequence again from the first step. A wrong press sends the game into a failure state. The game stays there until the next timing tick, then starts over at round one. Finishing the tenth round puts the game into a win state, which only reset can leave.

The switch inputs are asynchronous. Two flip-flops synchronize them before they are used. A press is the change of the synchronized switches from all-zero to any non-zero value, and each such change counts once. The timing tick comes from a free-running prescaler. At its default of 50,000,000 cycles the tick comes about once a second with a 50 MHz clock. All registers are cleared by a synchronous, active-high reset.

Top module: `seq_recall_game`

## Requirements
- R1: A pattern applied to `sw_in` goes through two synchronizing registers and an edge register. Its effect on the outputs appears after the third rising clock edge that follows the change, and not before.
- R2: The expected patterns, by step index 0 to 9, are 0001, 0010, 0100, 1000, 0001, 0010, 0100, 1000, 1000, 1000 (binary, `sw_in[3:0]`).
- R3: A switch value of 0000 is never a press. While the switches stay at zero, `step_idx`, `round_no` and `game_state` do not change, apart from the failure timeout of R6.
- R4: A press counts once, at the change from 0000 to a non-zero value. Holding the pattern does not count again until the switches return to 0000.
- R5: In the play state, a press that equals the entry at `step_idx` advances `step_idx` by one. When the matched entry is the last entry of the current round (`step_idx` = `round_no` − 1), `round_ok` pulses for one cycle, `round_no` increments and `step_idx` returns to 0.
- R6: A press that differs from the expected entry, including a pattern with more than one bit set, moves the game to the fail state. In that state `fail_flag` is high. On the next prescaler tick the game returns to play with `round_no` = 1 and `step_idx` = 0.
- R7: The prescaler tick occurs once every `TICK_DIV` clock cycles, counting from reset.
- R8: Completing round `SEQ_LEN` raises `round_ok` and enters the win state, with `win` high and `round_no` = `SEQ_LEN`. The game stays in the win state until reset and ignores any further presses.
- R9: After reset the block shows the play state, `round_no` = 1, `step_idx` = 0, and `round_ok`, `fail_flag` and `win` low.
- R10: `game_state` encodes the state as 0 = play, 1 = fail, 2 = win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_in | input | 4 | Asynchronous switch levels |
| game_state | output | 2 | Game state: 0 play, 1 fail, 2 win |
| round_no | output | $clog2(SEQ_LEN+1) | Current round, starting at 1 |
| step_idx | output | $clog2(SEQ_LEN+1) | Index of the next expected entry |
| round_ok | output | 1 | One-cycle pulse when a round is completed |
| fail_flag | output | 1 | High while in the fail state |
| win | output | 1 | High while in the win state |

## Verification
The bench uses `TICK_DIV` = 8 and keeps the default `SEQ_LEN` of 10. With this setting the fail timeout lasts only a few cycles, so the bench can play the whole ten-round game, repeat failures and recoveries, and still finish quickly. The short tick period also means a wrong press can land at any phase of the prescaler. This exercises both a fail state that ends almost at once and one that lasts nearly a full period.

// File: rtl/seq_recall_game.sv
module seq_recall_game #(
  parameter int SEQ_LEN  = 10,
  parameter int TICK_DIV = 50_000_000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [3:0]                     sw_in,
  output logic [1:0]                     game_state,
  output logic [$clog2(SEQ_LEN+1)-1:0]   round_no,
  output logic [$clog2(SEQ_LEN+1)-1:0]   step_idx,
  output logic                           round_ok,
  output logic                           fail_flag,
  output logic                           win
);
  localparam int RW = $clog2(SEQ_LEN + 1);
  localparam int CW = $clog2(TICK_DIV);

  typedef enum logic [1:0] {ST_PLAY = 2'd0, ST_FAIL = 2'd1, ST_WIN = 2'd2} st_t;

  function automatic logic [3:0] pattern_at(input int i);
    if (i < 8) return 4'(4'b0001 << (i % 4));
    return 4'b1000;
  endfunction

  logic [3:0]    sync1, sync2, prev;
  logic [CW-1:0] div_cnt;
  logic [RW-1:0] ptr, round;
  logic          ok_q;
  st_t           st;

  logic       press, tick, last_step, final_round;
  logic [3:0] expected;

  assign press       = (sync2 != 4'd0) && (prev == 4'd0);
  assign tick        = (div_cnt == CW'(TICK_DIV - 1));
  assign expected    = pattern_at(int'(ptr));
  assign last_step   = (ptr == round - 1'b1);
  assign final_round = (round == RW'(SEQ_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      div_cnt <= '0;
      ptr     <= '0;
      round   <= RW'(1);
      ok_q    <= 1'b0;
      st      <= ST_PLAY;
    end else begin
      sync1   <= sw_in;
      sync2   <= sync1;
      prev    <= sync2;
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      ok_q    <= 1'b0;
      case (st)
        ST_PLAY: if (press) begin
          if (sync2 == expected) begin
            if (last_step) begin
              ok_q <= 1'b1;
              ptr  <= '0;
              if (final_round) st <= ST_WIN;
              else             round <= round + 1'b1;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end else begin
            st <= ST_FAIL;
          end
        end
        ST_FAIL: if (tick) begin
          st    <= ST_PLAY;
          round <= RW'(1);
          ptr   <= '0;
        end
        default: ;
      endcase
    end
  end

  assign game_state = st;
  assign round_no   = round;
  assign step_idx   = ptr;
  assign round_ok   = ok_q;
  assign fail_flag  = (st == ST_FAIL);
  assign win        = (st == ST_WIN);

  assert_win_hold_R8: assert property (@(posedge clk) disable iff (rst)
    st == ST_WIN |=> st == ST_WIN);

  assert_fail_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAIL && !tick) |=> st == ST_FAIL);

  assert_fail_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAIL && tick) |=> (st == ST_PLAY && round == RW'(1) && ptr == '0));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PLAY && !press) |=> ($stable(ptr) && $stable(round) && st == ST_PLAY));

  assert_round_step_R5: assert property (@(posedge clk) disable iff (rst)
    (ok_q && st != ST_WIN) |-> round == $past(round) + 1'b1);

  assert_ptr_bound_R5: assert property (@(posedge clk) disable iff (rst)
    ptr < round);

  assert_tick_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    tick |=> div_cnt == '0);
endmodule

// File: tb/seq_recall_game_bench.sv
module seq_recall_game_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 8;
  localparam int SLEN = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sw  = 4'd0;
  logic [1:0] game_state;
  logic [3:0] round_no, step_idx;
  logic       round_ok, fail_flag, win;

  seq_recall_game #(.SEQ_LEN(SLEN), .TICK_DIV(DIV)) u_seq_recall_game (
    .clk(clk), .rst(rst), .sw_in(sw), .game_state(game_state),
    .round_no(round_no), .step_idx(step_idx), .round_ok(round_ok),
    .fail_flag(fail_flag), .win(win));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_err = 0;
  bit done = 0;
  int golden[SLEN] = '{1, 2, 4, 8, 1, 2, 4, 8, 8, 8};

  // behavioural reference model
  int m_st, m_round, m_ptr, m_rok, m_d1, m_d2, m_prev, m_cnt;
  bit m_press, m_tick;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_round = 1; m_ptr = 0; m_rok = 0;
      m_d1 = 0; m_d2 = 0; m_prev = 0; m_cnt = 0;
    end else begin
      m_press = (m_d2 != 0) && (m_prev == 0);
      m_tick  = (m_cnt == DIV - 1);
      m_cnt   = m_tick ? 0 : m_cnt + 1;
      m_rok   = 0;
      if (m_st == 0 && m_press) begin
        if (m_d2 == golden[m_ptr]) begin
          if (m_ptr + 1 == m_round) begin
            m_rok = 1; m_ptr = 0;
            if (m_round == SLEN) m_st = 2; else m_round++;
          end else m_ptr++;
        end else m_st = 1;
      end else if (m_st == 1 && m_tick) begin
        m_st = 0; m_round = 1; m_ptr = 0;
      end
      m_prev = m_d2; m_d2 = m_d1; m_d1 = int'(sw);
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(game_state) == m_st, "R10", "model game_state", int'(game_state), m_st);
      chk(int'(round_no) == m_round, "R5", "model round_no", int'(round_no), m_round);
      chk(int'(step_idx) == m_ptr, "R5", "model step_idx", int'(step_idx), m_ptr);
      chk(int'(round_ok) == m_rok, "R5", "model round_ok", int'(round_ok), m_rok);
      chk(int'(fail_flag) == int'(m_st == 1), "R6", "model fail_flag", int'(fail_flag), int'(m_st == 1));
      chk(int'(win) == int'(m_st == 2), "R8", "model win", int'(win), int'(m_st == 2));
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  task automatic press_pat(input logic [3:0] p, input int hold);
    @(negedge clk) sw = p;
    repeat (hold) @(negedge clk);
    sw = 4'd0;
    repeat (4) @(negedge clk);
  endtask

  task automatic play_round(input int r);
    for (int i = 0; i < r; i++) press_pat(4'(golden[i]), 4);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1; sw = 4'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int fail_len;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(game_state == 2'd0, "R9", "reset state", int'(game_state), 0);
    chk(round_no == 4'd1, "R9", "reset round", int'(round_no), 1);
    chk(step_idx == 4'd0 && !round_ok && !fail_flag && !win, "R9", "reset flags", int'(step_idx), 0);
    // R3 zero switches
    repeat (20) @(negedge clk);
    chk(step_idx == 4'd0 && round_no == 4'd1 && game_state == 2'd0, "R3", "idle zero", int'(round_no), 1);
    // R1 latency
    sw = 4'b0001;
    @(negedge clk); @(negedge clk);
    chk(round_no == 4'd1, "R1", "no effect after two edges", int'(round_no), 1);
    @(negedge clk);
    chk(round_no == 4'd2 && round_ok, "R1", "effect after third edge", int'(round_no), 2);
    sw = 4'd0; repeat (4) @(negedge clk);
    // R4 hold counts once
    press_pat(4'b0001, 15);
    chk(step_idx == 4'd1, "R4", "held press once", int'(step_idx), 1);
    press_pat(4'b0010, 2);
    chk(round_no == 4'd3 && step_idx == 4'd0, "R5", "round 2 done", int'(round_no), 3);
    for (int r = 3; r <= SLEN; r++) play_round(r);
    chk(win && game_state == 2'd2, "R8", "win reached", int'(game_state), 2);
    chk(round_no == 4'(SLEN), "R2", "all ten entries matched", int'(round_no), SLEN);
    press_pat(4'b0001, 3);
    press_pat(4'b0100, 3);
    chk(win && game_state == 2'd2, "R8", "win held", int'(game_state), 2);
    // R6 wrong press
    do_reset();
    play_round(1);
    press_pat(4'b0001, 3);
    @(negedge clk) sw = 4'b0100;
    repeat (3) @(negedge clk);
    chk(fail_flag && game_state == 2'd1, "R6", "fail on mismatch", int'(game_state), 1);
    sw = 4'd0;
    fail_len = 0;
    while (fail_flag && fail_len < 4 * DIV) begin fail_len++; @(negedge clk); end
    chk(fail_len >= 1 && fail_len <= DIV, "R7", "fail ends within tick period", fail_len, DIV);
    chk(round_no == 4'd1 && step_idx == 4'd0 && game_state == 2'd0, "R6", "restart", int'(round_no), 1);
    // multi-bit pattern mismatch
    press_pat(4'b0011, 2);
    repeat (DIV + 2) @(negedge clk);
    chk(round_no == 4'd1 && game_state == 2'd0, "R6", "recover after 0011", int'(round_no), 1);
    for (int r = 1; r <= 3; r++) play_round(r);
    chk(round_no == 4'd4, "R5", "round 4 after recovery", int'(round_no), 4);
    // mismatch mid-round at another tick phase
    press_pat(4'b0001, 2);
    press_pat(4'b1000, 5);
    repeat (DIV + 2) @(negedge clk);
    chk(round_no == 4'd1 && !fail_flag, "R6", "restart mid-round", int'(round_no), 1);
    report();
  end
endmodule